// File: doc/BRIEF.md
# Three-Multiplier Complex Twiddle Multiplier

This block rotates one complex sample per clock by a twiddle factor e^(-jθ), where θ = 2πk/N, N = 2^IW and k is the twiddle index presented with the sample. It sits between the short DFT kernels of a mid-size FFT stage. In that position the number of distinct angles is small enough for a compact coefficient table held inside the block.

The usual product needs four real multiplications. This block needs three. It forms the pre-sums (AR + AI) and (AI − AR) and multiplies them by the stored sine and cosine. The product AR·d, with d = cos θ − sin θ, is added to both of those partial results. All three real multipliers are radix-4 Booth arrays.

The datapath has three register stages: pre-add with table lookup, multiply, then post-add with rounding and saturation. The flag `out_valid` follows `in_valid` through the same three stages. The block decides nothing about which index comes next; the caller supplies the index with every sample.

Top module: `cmul3_twiddle`

## Requirements
- R1: While `rst_n` is low, and on the first edges after release until a captured sample reaches the end of the pipeline, `out_valid` is 0.
- R2: A sample captured with `in_valid` = 1 at a rising edge appears on `out_re`/`out_im` with `out_valid` = 1 just after the second following rising edge, which is three register stages. One sample is accepted every clock, and cycles with `in_valid` = 0 leave `out_valid` = 0 in the matching output cycle.
- R3: The table entry for index k holds S = round(2^(TW-2)·sin(2πk/N)) and C = round(2^(TW-2)·cos(2πk/N)), signed with 1.0 = 16384 for TW = 16, and d = C − S exactly. Rounding is to the nearest integer. With input (16384, 0), the result for index k reads back (C, −S).
- R4: The real result is computed from the Booth products (AR+AI)·S + AR·d, which is equal to AR·C + AI·S, and then scaled down by 2^(TW-2).
- R5: The imaginary result is computed as (AI−AR)·C + AR·d, which is equal to AI·C − AR·S, and then scaled down by 2^(TW-2).
- R6: Scaling is floor((P + 2^(TW-3)) / 2^(TW-2)), which rounds half upward. The scaled value is then clamped to [−32768, 32767].
- R7: Index 0 gives an exact pass-through: `out_re` = AR and `out_im` = AI for every input value.
- R8: Index N/4 (θ = π/2) gives `out_re` = AI and `out_im` = −AR. An input of −32768 maps to 32767.
- R9: Full-scale inputs of either sign give correct results at every index. The pre-sums carry one extra bit, so they never wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_re | input | DW | Real part AR, signed |
| in_im | input | DW | Imaginary part AI, signed |
| tw_idx | input | IW | Twiddle index k, θ = 2πk/2^IW |
| out_valid | output | 1 | Output sample qualifier |
| out_re | output | DW | Real part of rotated sample, signed |
| out_im | output | DW | Imaginary part of rotated sample, signed |

## Verification
The bench builds the block with its defaults: DW = 16, TW = 16 and IW = 5. A 32-entry table can be swept completely through the ports. The exact angles 0, π/4, π/2 and 3π/4 all exist as indices, which puts both saturation directions and the widest pre-sum (AI − AR = 65535) within reach of directed vectors. A behavioural model uses the four-product form with a queue as the pipeline. It is compared every clock against a random stream that contains bubbles.

// File: rtl/cmul3_pkg.sv
package cmul3_pkg;

    localparam real TWO_PI = 6.283185307179586;

    // Quantised sine or cosine of 2*pi*k/n scaled by 2^frac, rounded to nearest.
    function automatic int q_trig(input int k, input int n, input int frac, input bit pick_cos);
        real ang;
        real v;
        ang = TWO_PI * k / n;
        v   = pick_cos ? $cos(ang) : $sin(ang);
        return int'(v * real'(64'd1 << frac));
    endfunction

endpackage

// File: rtl/cmul3_tw_rom.sv
module cmul3_tw_rom #(
    parameter int IW = 5,
    parameter int TW = 16
) (
    input  logic [IW-1:0]        idx,
    output logic signed [TW-1:0] sin_o,
    output logic signed [TW-1:0] cos_o,
    output logic signed [TW-1:0] dif_o
);
    localparam int NENT = 1 << IW;
    localparam int FRAC = TW - 2;

    logic signed [TW-1:0] sin_t [NENT];
    logic signed [TW-1:0] cos_t [NENT];
    logic signed [TW-1:0] dif_t [NENT];

    for (genvar k = 0; k < NENT; k++) begin : g_ent
        localparam int SQ = cmul3_pkg::q_trig(k, NENT, FRAC, 1'b0);
        localparam int CQ = cmul3_pkg::q_trig(k, NENT, FRAC, 1'b1);
        assign sin_t[k] = TW'(SQ);
        assign cos_t[k] = TW'(CQ);
        assign dif_t[k] = TW'(CQ - SQ);
    end

    assign sin_o = sin_t[idx];
    assign cos_o = cos_t[idx];
    assign dif_o = dif_t[idx];
endmodule

// File: rtl/cmul3_booth_mult.sv
module cmul3_booth_mult #(
    parameter int AW = 17,
    parameter int BW = 16,
    parameter int PW = AW + BW
) (
    input  logic signed [AW-1:0] a,
    input  logic signed [BW-1:0] b,
    output logic signed [PW-1:0] p
);
    localparam int NPP = (BW + 1) / 2;

    logic signed [2*NPP:0] bx;
    logic signed [PW-1:0]  ae;
    logic signed [PW-1:0]  pp;
    logic signed [PW-1:0]  acc;
    logic [2:0]            grp;

    always_comb begin
        bx  = {(2*NPP)'(b), 1'b0};
        ae  = PW'(a);
        acc = '0;
        pp  = '0;
        grp = '0;
        for (int i = 0; i < NPP; i++) begin
            grp = bx[2*i +: 3];
            unique case (grp)
                3'b001, 3'b010: pp = ae;
                3'b011:         pp = ae <<< 1;
                3'b100:         pp = -(ae <<< 1);
                3'b101, 3'b110: pp = -ae;
                default:        pp = '0;
            endcase
            acc = acc + (pp <<< (2*i));
        end
        p = acc;
    end
endmodule

// File: rtl/cmul3_round_sat.sv
module cmul3_round_sat #(
    parameter int XW   = 34,
    parameter int OW   = 16,
    parameter int FRAC = 14
) (
    input  logic signed [XW-1:0] x,
    output logic signed [OW-1:0] y
);
    localparam logic signed [XW:0] HALF = (XW+1)'(64'd1 << (FRAC-1));
    localparam logic signed [XW:0] MAXV = (XW+1)'((64'd1 << (OW-1)) - 64'd1);
    localparam logic signed [XW:0] MINV = ~MAXV;

    logic signed [XW:0] biased;
    logic signed [XW:0] shifted;

    always_comb begin
        biased  = (XW+1)'(x) + HALF;
        shifted = biased >>> FRAC;
        if (shifted > MAXV)
            y = MAXV[OW-1:0];
        else if (shifted < MINV)
            y = MINV[OW-1:0];
        else
            y = shifted[OW-1:0];
    end
endmodule

// File: rtl/cmul3_twiddle.sv
module cmul3_twiddle #(
    parameter int DW = 16,
    parameter int TW = 16,
    parameter int IW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    input  logic [IW-1:0]        tw_idx,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im
);
    localparam int FRAC = TW - 2;
    localparam int SW   = DW + 1;
    localparam int PWS  = SW + TW;
    localparam int PWD  = DW + TW;
    localparam int AW   = PWS + 1;

    // table lookup
    logic signed [TW-1:0] t_sin, t_cos, t_dif;

    cmul3_tw_rom #(.IW(IW), .TW(TW)) u_rom (
        .idx   (tw_idx),
        .sin_o (t_sin),
        .cos_o (t_cos),
        .dif_o (t_dif)
    );

    // stage 1: pre-add
    logic                 s1_v;
    logic signed [DW-1:0] s1_ar;
    logic signed [SW-1:0] s1_sum, s1_dif;
    logic signed [TW-1:0] s1_sin, s1_cos, s1_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s1_v <= 1'b0;
        else        s1_v <= in_valid;
    end

    always_ff @(posedge clk) begin
        s1_ar  <= in_re;
        s1_sum <= SW'(in_re) + SW'(in_im);
        s1_dif <= SW'(in_im) - SW'(in_re);
        s1_sin <= t_sin;
        s1_cos <= t_cos;
        s1_d   <= t_dif;
    end

    // stage 2: three Booth products
    logic signed [PWS-1:0] m_ps, m_pc;
    logic signed [PWD-1:0] m_pd;

    cmul3_booth_mult #(.AW(SW), .BW(TW)) u_mul_s (.a(s1_sum), .b(s1_sin), .p(m_ps));
    cmul3_booth_mult #(.AW(SW), .BW(TW)) u_mul_c (.a(s1_dif), .b(s1_cos), .p(m_pc));
    cmul3_booth_mult #(.AW(DW), .BW(TW)) u_mul_d (.a(s1_ar),  .b(s1_d),   .p(m_pd));

    logic                  s2_v;
    logic signed [PWS-1:0] s2_ps, s2_pc;
    logic signed [PWD-1:0] s2_pd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s2_v <= 1'b0;
        else        s2_v <= s1_v;
    end

    always_ff @(posedge clk) begin
        s2_ps <= m_ps;
        s2_pc <= m_pc;
        s2_pd <= m_pd;
    end

    // stage 3: post-add, round, saturate
    logic signed [AW-1:0] re_full, im_full;
    logic signed [DW-1:0] re_rs, im_rs;

    always_comb begin
        re_full = AW'(s2_ps) + AW'(s2_pd);
        im_full = AW'(s2_pc) + AW'(s2_pd);
    end

    cmul3_round_sat #(.XW(AW), .OW(DW), .FRAC(FRAC)) u_rs_re (.x(re_full), .y(re_rs));
    cmul3_round_sat #(.XW(AW), .OW(DW), .FRAC(FRAC)) u_rs_im (.x(im_full), .y(im_rs));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= s2_v;
    end

    always_ff @(posedge clk) begin
        out_re <= re_rs;
        out_im <= im_rs;
    end
endmodule

// File: rtl/cmul3_twiddle_chk.sv
module cmul3_twiddle_chk #(
    parameter int DW = 16,
    parameter int IW = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic signed [DW-1:0] in_re,
    input logic signed [DW-1:0] in_im,
    input logic [IW-1:0]        tw_idx,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_re,
    input logic signed [DW-1:0] out_im
);
    localparam logic [IW-1:0] QIDX = IW'(1 << (IW-2));
    localparam logic signed [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] MOST_POS = {1'b0, {(DW-1){1'b1}}};

    logic [2:0] vp, zp, qp;
    logic signed [DW-1:0] rp [3];
    logic signed [DW-1:0] ip [3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vp <= '0;
            zp <= '0;
            qp <= '0;
        end else begin
            vp <= {vp[1:0], in_valid};
            zp <= {zp[1:0], in_valid && (tw_idx == '0)};
            qp <= {qp[1:0], in_valid && (tw_idx == QIDX)};
        end
    end

    always_ff @(posedge clk) begin
        rp[0] <= in_re;  rp[1] <= rp[0]; rp[2] <= rp[1];
        ip[0] <= in_im;  ip[1] <= ip[0]; ip[2] <= ip[1];
    end

    function automatic logic signed [DW-1:0] neg_sat(input logic signed [DW-1:0] v);
        return (v == MOST_NEG) ? MOST_POS : -v;
    endfunction

    a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !out_valid);

    a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vp[2]);

    a_r7_zero_angle: assert property (@(posedge clk) disable iff (!rst_n)
        zp[2] |-> (out_re == rp[2] && out_im == ip[2]));

    a_r8_quarter_turn: assert property (@(posedge clk) disable iff (!rst_n)
        qp[2] |-> (out_re == ip[2] && out_im == neg_sat(rp[2])));

    a_r4_known_result: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown({out_re, out_im}));
endmodule

bind cmul3_twiddle cmul3_twiddle_chk #(.DW(DW), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_re     (in_re),
    .in_im     (in_im),
    .tw_idx    (tw_idx),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im)
);

// File: tb/cmul3_twiddle_tb_top.sv
module cmul3_twiddle_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 16;
    localparam int TW  = 16;
    localparam int IW  = 5;
    localparam int NPT = 1 << IW;
    localparam int SC  = 1 << (TW - 2);

    typedef struct {
        bit    v;
        int    re;
        int    im;
        string tag;
    } rec_t;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 in_valid;
    logic signed [DW-1:0] in_re, in_im;
    logic [IW-1:0]        tw_idx;
    logic                 out_valid;
    logic signed [DW-1:0] out_re, out_im;

    int   vectors = 0;
    int   miscompares = 0;
    rec_t pend[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmul3_twiddle #(.DW(DW), .TW(TW), .IW(IW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_re     (in_re),
        .in_im     (in_im),
        .tw_idx    (tw_idx),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    function automatic int qtrig(int k, bit use_cos);
        real a;
        a = 2.0 * 3.141592653589793 * k / NPT;
        return int'((use_cos ? $cos(a) : $sin(a)) * real'(SC));
    endfunction

    function automatic int rsat(longint x);
        longint r;
        r = (x + longint'(SC / 2)) >>> (TW - 2);
        if (r > 32767)  return 32767;
        if (r < -32768) return -32768;
        return int'(r);
    endfunction

    task automatic check_out();
        rec_t r;
        if (pend.size() == 3) begin
            r = pend.pop_front();
            vectors++;
            if (out_valid !== r.v ||
                (r.v && (out_re !== r.re || out_im !== r.im))) begin
                miscompares++;
                $display("FAIL %s: got v=%0b re=%0d im=%0d, expected v=%0b re=%0d im=%0d",
                         r.tag, out_valid, out_re, out_im, r.v, r.re, r.im);
            end
        end else begin
            vectors++;
            if (out_valid !== 1'b0) begin
                miscompares++;
                $display("FAIL R1: got out_valid=%0b while filling, expected 0", out_valid);
            end
        end
    endtask

    task automatic step(bit v, int re, int im, int k, string tag);
        rec_t r;
        int c, s;
        @(negedge clk);
        check_out();
        in_valid = v;
        in_re    = DW'(re);
        in_im    = DW'(im);
        tw_idx   = IW'(k);
        c = qtrig(k, 1'b1);
        s = qtrig(k, 1'b0);
        r.v   = v;
        r.re  = rsat(longint'(re) * c + longint'(im) * s);
        r.im  = rsat(longint'(im) * c - longint'(re) * s);
        r.tag = tag;
        pend.push_back(r);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        miscompares++;
        $display("FAIL watchdog: got no end of run, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_re    = '0;
        in_im    = '0;
        tw_idx   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0) begin
            miscompares++;
            $display("FAIL R1: got out_valid=%0b in reset, expected 0", out_valid);
        end
        rst_n = 1'b1;

        // R7: index 0 pass-through
        step(1, 1234, -567, 0, "R7");
        step(1, 32767, -32768, 0, "R7");
        step(1, -32768, 32767, 0, "R7");
        step(1, 0, 0, 0, "R7");
        // R8: quarter turn
        step(1, 100, 200, NPT/4, "R8");
        step(1, -32768, 5, NPT/4, "R8");
        step(1, 32767, -32768, NPT/4, "R8");
        // R6: rounding and saturation at pi/4 and -pi/4
        step(1, -32768, -32768, NPT/8, "R6");
        step(1, 32767, 32767, NPT/8, "R6");
        step(1, 32767, -32768, NPT - NPT/8, "R6");
        step(1, 3, 1, NPT/8, "R6");
        // R9: widest pre-sums
        step(1, -32768, 32767, 3*NPT/8, "R9");
        step(1, 32767, 32767, 3*NPT/8, "R9");
        step(1, -32768, -32768, 5*NPT/8, "R9");
        // R3: table read-back through unit input
        for (int k = 0; k < NPT; k++) step(1, SC, 0, k, "R3");
        // R2: bubbles
        step(0, 0, 0, 0, "R2");
        step(1, 777, -888, 3, "R2");
        step(0, 5, 5, 1, "R2");
        step(0, 5, 5, 1, "R2");
        step(1, -999, 111, 7, "R2");
        // R4, R5: random stream with bubbles
        for (int n = 0; n < 600; n++) begin
            int re, im;
            bit v;
            v  = ($urandom_range(0, 3) != 0);
            re = (n % 17 == 0) ? -32768 : int'($urandom_range(0, 65535)) - 32768;
            im = (n % 13 == 0) ? 32767  : int'($urandom_range(0, 65535)) - 32768;
            step(v, re, im, int'($urandom_range(0, NPT-1)), "R4,R5");
        end
        // drain
        for (int n = 0; n < 3; n++) step(0, 0, 0, 0, "R2");
        @(negedge clk);
        check_out();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule